// File: doc/BRIEF.md
# Serial Command Register Bank

This block is a serial-peripheral slave that turns 8-bit command words from a host into a bank of small configuration registers. Each word carries a 3-bit register address, 4 bits of data and a top bit. The top bit selects one of two output copies for registers marked per-output, and it also serves as a watchdog toggle. The slave runs on a fast system clock. It synchronises the serial clock, chip select and data-in lines and acts on their edges, so the serial clock must be several times slower than the system clock.

While chip select is low, the data-in line is sampled on each serial-clock rising edge. The data-out line changes on falling edges. It first carries a status byte captured when chip select falls, and then carries the data-in stream delayed by eight clocks, so that several slaves can be daisy-chained. When chip select rises, a frame with a whole, non-zero number of bytes has its last eight bits decoded and written. Any other frame is dropped.

The frame state machine has four states. IDLE waits for chip select to fall. ACTIVE shifts bits while chip select is low. COMMIT is a one-cycle write of the received word. DROP is a one-cycle discard. Its transitions are: IDLE to ACTIVE on a chip-select fall; ACTIVE to COMMIT on a chip-select rise with a whole byte count; ACTIVE to DROP on a chip-select rise with any other count; COMMIT or DROP to IDLE, or straight back to ACTIVE if chip select falls again in that cycle.

Top module: `spi_cmd_regs`

## Requirements
- R1: A word is shifted in most significant bit first. Bit 7 is the select/watchdog bit, bits 6:4 are the register address and bits 3:0 are the data. An accepted word with the data D and the address A writes D into register A.
- R2: For a register whose bit in PER_OUT_MASK is 0 (addresses 0 to 3 by default), a write updates both output copies. For a register whose bit is 1 (addresses 4 to 7), a write updates only the copy that bit 7 selects, and the other copy keeps its value. Copy o of register a sits at cfg_q[(o*8+a)*4 +: 4].
- R3: A frame may hold several words back to back. Only the last eight bits shifted in before chip select rises are decoded.
- R4: A frame whose serial-clock count is zero or not a multiple of eight changes no register and no watchdog history.
- R5: During the first eight serial clocks of a frame, so carries the status byte MSB first. Bit 7 is visible before the first rising edge, and so changes only after serial-clock falling edges.
- R6: From the ninth serial clock onward, so carries the bits received on si, delayed by eight clocks.
- R7: so_oe is high only while a frame is in progress, and low whenever chip select is high.
- R8: wd_kick pulses for one cycle for an accepted word when no word has been accepted since reset, or when its bit 7 differs from bit 7 of the previous accepted word.
- R9: An active-low reset clears every register, the watchdog history and so_oe.
- R10: The status byte is captured when chip select falls. Later changes of status_in do not affect the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| csb | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| status_in | input | 8 | Status byte, captured when chip select falls |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for so; when low, the pad is high-impedance |
| cfg_q | output | 64 | Register contents, two copies of eight 4-bit registers |
| wd_kick | output | 1 | One-cycle watchdog-satisfied pulse |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, a 3-bit address, 4-bit data and a mask that makes addresses 4 to 7 per-output. With these values, every register and both copies can be reached in a few hundred frames, and a frame of up to 32 bits exercises multi-word chaining. Directed frames cover partial, empty and triple-word frames, repeated and toggled select bits, and a reset in the middle of a run. Seeded random frames of mixed length are then checked against a bench model of the registers, the data-out stream and the watchdog pulse count.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACTIVE = 2'd1,
        S_COMMIT = 2'd2,
        S_DROP   = 2'd3
    } frame_state_e;

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int           STAGES  = 2,
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[s] <= RST_VAL;
                end else if (s == 0) begin
                    pipe[s] <= d;
                end else begin
                    pipe[s] <= pipe[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame
    import spi_cmd_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csb_s,
    input  logic              si_s,
    input  logic [WORD_W-1:0] status_in,
    output logic              so,
    output logic              so_oe,
    output logic              commit_vld,
    output logic [WORD_W-1:0] commit_word
);

    localparam int                CNT_W    = $clog2(WORD_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(WORD_W - 1);

    frame_state_e      state_q, state_d;
    logic              sclk_d, csb_d;
    logic              sclk_rise, sclk_fall, csb_rise, csb_fall;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              got_byte;
    logic              so_q;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign csb_rise  = csb_s & ~csb_d;
    assign csb_fall  = ~csb_s & csb_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (csb_fall) state_d = S_ACTIVE;
            S_ACTIVE: if (csb_rise) state_d = (bit_cnt == '0 && got_byte) ? S_COMMIT : S_DROP;
            S_COMMIT: state_d = csb_fall ? S_ACTIVE : S_IDLE;
            S_DROP:   state_d = csb_fall ? S_ACTIVE : S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sclk_d  <= 1'b0;
            csb_d   <= 1'b1;
        end else begin
            state_q <= state_d;
            sclk_d  <= sclk_s;
            csb_d   <= csb_s;
        end
    end

    // shift path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            got_byte <= 1'b0;
            so_q     <= 1'b0;
        end else if (csb_fall) begin
            shreg    <= status_in;
            so_q     <= status_in[WORD_W-1];
            bit_cnt  <= '0;
            got_byte <= 1'b0;
        end else if (state_q == S_ACTIVE) begin
            if (sclk_rise) begin
                shreg   <= {shreg[WORD_W-2:0], si_s};
                bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) got_byte <= 1'b1;
            end
            if (sclk_fall) so_q <= shreg[WORD_W-1];
        end
    end

    // outputs
    always_comb begin
        so_oe       = (state_q == S_ACTIVE);
        commit_vld  = (state_q == S_COMMIT);
        commit_word = shreg;
        so          = so_q;
    end

    // R4: a commit only follows a whole, non-empty byte count
    a_r4_whole_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld |-> (bit_cnt == '0 && got_byte));

    // R5: first driven bit is the captured status MSB
    a_r5_status_msb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> (so == $past(status_in[WORD_W-1])));

    // R5: so moves only after a serial-clock falling edge while driven
    a_r5_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && !$past(sclk_fall)) |-> $stable(so));

    // R7: driver released once chip select is seen high
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(csb_s) && csb_s) |-> !so_oe);

endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile #(
    parameter int                         ADDR_W       = 3,
    parameter int                         DATA_W       = 4,
    parameter logic [(1<<ADDR_W)-1:0]     PER_OUT_MASK = 8'hF0
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       commit_vld,
    input  logic [ADDR_W+DATA_W:0]                     commit_word,
    output logic [2*(1<<ADDR_W)*DATA_W-1:0]            cfg_q,
    output logic                                       wd_kick
);

    localparam int NUM_REG = 1 << ADDR_W;
    localparam int NUM_OUT = 2;
    localparam int WORD_W  = ADDR_W + DATA_W + 1;

    logic              sel;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] reg_q [NUM_OUT][NUM_REG];
    logic              wd_seen, wd_last;

    assign sel  = commit_word[WORD_W-1];
    assign addr = commit_word[DATA_W +: ADDR_W];
    assign data = commit_word[DATA_W-1:0];

    generate
        for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
            for (genvar a = 0; a < NUM_REG; a++) begin : g_reg
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        reg_q[o][a] <= '0;
                    end else if (commit_vld && addr == ADDR_W'(a) &&
                                 (!PER_OUT_MASK[a] || sel == o[0])) begin
                        reg_q[o][a] <= data;
                    end
                end
                assign cfg_q[(o*NUM_REG+a)*DATA_W +: DATA_W] = reg_q[o][a];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_seen <= 1'b0;
            wd_last <= 1'b0;
            wd_kick <= 1'b0;
        end else begin
            wd_kick <= commit_vld && (!wd_seen || sel != wd_last);
            if (commit_vld) begin
                wd_seen <= 1'b1;
                wd_last <= sel;
            end
        end
    end

    // R1: a shared-register write lands in copy 0
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_vld && !PER_OUT_MASK[addr]) |=> (reg_q[0][$past(addr)] == $past(data)));

    // R2: per-output write leaves the unselected copy alone
    a_r2_other_copy_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_vld && PER_OUT_MASK[addr] && sel) |=> $stable(reg_q[0][$past(addr)]));

    // R8: a kick only follows a commit
    a_r8_kick_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wd_kick |-> $past(commit_vld));

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs #(
    parameter int                     SYNC_STAGES  = 2,
    parameter int                     ADDR_W       = 3,
    parameter int                     DATA_W       = 4,
    parameter logic [(1<<ADDR_W)-1:0] PER_OUT_MASK = 8'hF0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                sclk,
    input  logic                                csb,
    input  logic                                si,
    input  logic [ADDR_W+DATA_W:0]              status_in,
    output logic                                so,
    output logic                                so_oe,
    output logic [2*(1<<ADDR_W)*DATA_W-1:0]     cfg_q,
    output logic                                wd_kick
);

    localparam int WORD_W = ADDR_W + DATA_W + 1;

    logic              csb_s, sclk_s, si_s;
    logic              commit_vld;
    logic [WORD_W-1:0] commit_word;

    spi_cmd_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (3),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({csb, sclk, si}),
        .q     ({csb_s, sclk_s, si_s})
    );

    spi_cmd_frame #(
        .WORD_W (WORD_W)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (sclk_s),
        .csb_s       (csb_s),
        .si_s        (si_s),
        .status_in   (status_in),
        .so          (so),
        .so_oe       (so_oe),
        .commit_vld  (commit_vld),
        .commit_word (commit_word)
    );

    spi_cmd_regfile #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .PER_OUT_MASK (PER_OUT_MASK)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_vld  (commit_vld),
        .commit_word (commit_word),
        .cfg_q       (cfg_q),
        .wd_kick     (wd_kick)
    );

endmodule

// File: tb/spi_cmd_regs_bench.sv
module spi_cmd_regs_bench;

    localparam int HP = 6;
    localparam logic [7:0] MASK = 8'hF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        csb = 1'b1;
    logic        si = 1'b0;
    logic [7:0]  status_in = 8'h00;
    logic        so, so_oe, wd_kick;
    logic [63:0] cfg_q;

    int checks = 0;
    int errors = 0;
    int kick_cnt = 0;
    int exp_kicks = 0;
    bit done = 1'b0;

    logic [3:0] exp_reg [2][8];
    bit         exp_seen;
    bit         exp_last;

    always #4 clk = ~clk;

    spi_cmd_regs u_spi_cmd_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .csb       (csb),
        .si        (si),
        .status_in (status_in),
        .so        (so),
        .so_oe     (so_oe),
        .cfg_q     (cfg_q),
        .wd_kick   (wd_kick)
    );

    always @(posedge clk) if (rst_n && wd_kick) kick_cnt <= kick_cnt + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] v;
        for (int o = 0; o < 2; o++)
            for (int a = 0; a < 8; a++)
                v[(o*8+a)*4 +: 4] = exp_reg[o][a];
        return v;
    endfunction

    function automatic void model_reset();
        for (int o = 0; o < 2; o++)
            for (int a = 0; a < 8; a++)
                exp_reg[o][a] = 4'h0;
        exp_seen = 1'b0;
        exp_last = 1'b0;
    endfunction

    function automatic void model_word(input logic [7:0] w);
        for (int o = 0; o < 2; o++)
            if (!MASK[w[6:4]] || w[7] == o[0]) exp_reg[o][w[6:4]] = w[3:0];
        if (!exp_seen || w[7] != exp_last) exp_kicks++;
        exp_seen = 1'b1;
        exp_last = w[7];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        check(so_oe == 1'b0, "R9 so_oe in reset", {63'b0, so_oe}, 64'd0);
        check(cfg_q == 64'd0, "R9 registers cleared", cfg_q, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // bits are left-aligned: bit k of the frame is bits[31-k]
    task automatic run_frame(input logic [31:0] bits, input int n, input logic [7:0] st,
                             input logic [7:0] st_late, input string req);
        logic [31:0] got_s = '0;
        logic [31:0] exp_s = '0;
        logic [31:0] got_e = '0;
        logic [31:0] exp_e = '0;
        bit oe_ok = 1'b1;
        @(negedge clk);
        status_in = st;
        csb = 1'b0;
        repeat (HP) @(negedge clk);
        status_in = st_late;   // R10: must not reach so
        for (int k = 0; k < n; k++) begin
            si = bits[31-k];
            repeat (HP) @(negedge clk);
            if (!so_oe) oe_ok = 1'b0;
            if (k < 8) begin
                got_s[k] = so;
                exp_s[k] = st[7-k];
            end else begin
                got_e[k-8] = so;
                exp_e[k-8] = bits[31-(k-8)];
            end
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        csb = 1'b1;
        si = 1'b0;
        repeat (12) @(negedge clk);
        if (n > 0 && n % 8 == 0) model_word(bits[39-n -: 8]);
        if (n >= 8) check(got_s == exp_s, "R5/R10 status stream", {32'b0, got_s}, {32'b0, exp_s});
        if (n > 8) check(got_e == exp_e, "R6 echo stream", {32'b0, got_e}, {32'b0, exp_e});
        if (n > 0) check(oe_ok, "R7 so_oe during frame", {63'b0, oe_ok}, 64'd1);
        check(so_oe == 1'b0, "R7 so_oe after frame", {63'b0, so_oe}, 64'd0);
        check(cfg_q == model_flat(), req, cfg_q, model_flat());
        check(kick_cnt == exp_kicks, "R8 kick count", 64'(kick_cnt), 64'(exp_kicks));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        do_reset();
        check(kick_cnt == 0, "R9 no kick after reset", 64'(kick_cnt), 64'd0);

        // R1: shared address 1, data 5, select 0
        run_frame({8'h15, 24'h0}, 8, 8'hA5, 8'h3C, "R1 shared write");
        // R2: per-output address 5, select 1, data A
        run_frame({8'hDA, 24'h0}, 8, 8'h5A, 8'hFF, "R2 per-output copy 1");
        // R8: select 1 again, no kick; address 4 copy 1
        run_frame({8'hC3, 24'h0}, 8, 8'h81, 8'h00, "R8 repeated select");
        // R2: address 5 copy 0, copy 1 keeps A
        run_frame({8'h5E, 24'h0}, 8, 8'h01, 8'h10, "R2 per-output copy 0");
        // R3: three words, only the last decoded
        run_frame({8'h11, 8'h22, 8'hA7, 8'h0}, 24, 8'hC6, 8'h39, "R3 last word wins");
        // R4: partial and empty frames
        run_frame({8'h7F, 8'hF0, 16'h0}, 12, 8'h44, 8'h00, "R4 twelve bits dropped");
        run_frame({8'hFE, 24'h0}, 7, 8'h44, 8'h00, "R4 seven bits dropped");
        run_frame(32'h0, 0, 8'h44, 8'h00, "R4 empty frame dropped");
        run_frame({8'h9D, 8'h46, 8'h31, 8'hF2}, 32, 8'hE7, 8'h18, "R3 four words");

        for (int i = 0; i < 60; i++) begin
            int n;
            if ($urandom_range(0, 3) != 0) n = 8 * $urandom_range(1, 4);
            else n = $urandom_range(0, 31);
            run_frame($urandom, n, 8'($urandom), 8'($urandom), "R1 random frame");
        end

        do_reset();
        run_frame({8'h80, 24'h0}, 8, 8'h00, 8'hFF, "R9 first word after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule